// File: doc/BRIEF.md
# EDC Mode and Diagnostic Controller

This block sits beside a 64-bit error detection and correction core. It holds the configuration that tells the core what to do, and it keeps the diagnostic record of what the core has seen. A 16-bit system data bus loads a mode register. The register selects one of five operating modes, a parity sense and a buffer arrangement. The block tells the core when to generate checkbits and when to correct data.

On every memory read the block takes the raw word, the stored checkbits and the core's freshly generated checkbits. In injection mode a latched test value replaces the stored checkbits. The block forms the syndrome and classifies the read as clean, single-bit or multi-bit. It then drives two active-low error flags.

Error events update a set of diagnostic registers: the first failing data word, the last syndrome, the last checkbits compared, a saturating event count and the last error type. Software reads these back over the same 16-bit bus in the two readout modes, or reads the mode register itself. One clear bit in a mode write empties all diagnostic state. This gives an all-zero source for initialising memory.

Top module: `edc_diag_ctrl`

## Requirements
- R1: The mode register loads from `sd_in` on a rising clock edge only while `mode_en` is high, and holds otherwise. The layout is: bits 2:0 mode, bit 3 clear, bit 4 parity sense, bit 5 register readback, bit 6 dual buffer. Bits 15:7 are ignored.
- R2: Mode codes are 000 error-data readout, 001 diagnostic readout, 010 generate-detect, 011 normal and 100 injection. `core_gen_en` is high in 010, 011 and 100. `core_correct_en` is high only in 011.
- R3: A mode write with bit 3 set zeroes, at that same edge, the error-data word, syndrome, compared checkbits, count, type and injection latch, and returns both flags high. The clear bit is not stored and reads back as 0.
- R4: On a read strobe the syndrome is the compared checkbits XOR `gen_chk`. A zero syndrome gives `err_n`=1 and `merr_n`=1. An odd-weight syndrome gives `err_n`=0 and `merr_n`=1. An even-weight nonzero syndrome drives both flags to 0. The flags change only on a read strobe or a clear, one cycle after the strobe.
- R5: `chk_load` copies `sd_in[7:0]` into the injection latch only in mode 100. In that mode the latch replaces `rd_chk` in the compare, and any nonzero syndrome drives both flags to 0.
- R6: The error-data register captures `rd_data` on the first error after reset or clear, and then holds it until the next clear.
- R7: Every error read updates the syndrome, the compared checkbits and the type (01 single, 10 multi, 00 after clear). Clean reads leave them unchanged.
- R8: The error count increments on each error read and saturates at 2^CNT_W-1.
- R9: In mode 000 `sd_out` shows the 16-bit slice of the error-data word chosen by `diag_sel[1:0]`. Slice 0 is bits 15:0.
- R10: In mode 001 `diag_sel` picks a register, zero-extended: 0 injection latch, 1 compared checkbits, 2 syndrome, 3 count, 4 type. Indices 5 to 7 read 0.
- R11: With bit 5 set, `sd_out` shows the mode register image in any mode, with unused bits as 0. Otherwise modes 010, 011 and 100 drive `sd_out` to 0.
- R12: `parity_even` follows bit 4 (0 odd, 1 even), and `fifo_dual` follows bit 6 (0 single deep buffer, 1 two half-size buffers).
- R13: During reset and after it, the mode is 000, all diagnostic state is zero and both flags are high. Reset asserts asynchronously and releases after two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_en | input | 1 | Mode register write enable |
| sd_in | input | 16 | System data bus input |
| chk_load | input | 1 | Injection latch load strobe |
| diag_sel | input | 3 | Readback slice or register index |
| rd_valid | input | 1 | Memory read strobe |
| rd_data | input | 64 | Raw data word from memory |
| rd_chk | input | 8 | Stored checkbits from memory |
| gen_chk | input | 8 | Checkbits generated by the core |
| sd_out | output | 16 | Readback onto the system bus |
| err_n | output | 1 | Error flag, active low |
| merr_n | output | 1 | Multi-bit error flag, active low |
| core_gen_en | output | 1 | Core checkbit generation enable |
| core_correct_en | output | 1 | Core correction enable |
| parity_even | output | 1 | Parity sense, 1 for even |
| fifo_dual | output | 1 | Buffer split selection |

## Verification
The assertions check these properties on every cycle:
- The mode register holds unless `mode_en` is high.
- A multi-bit flag never appears without the error flag.
- The flags hold between read strobes.
- A clear zeroes the state.
- The captured word holds after the first error.
- The count holds at saturation.
- The injection latch does not move outside injection mode.

Only the bench scenarios can show the rest:
- the mode decode to the core enables;
- the odd and even syndrome classes;
- the substitution of latched checkbits in injection mode;
- the slice and index layout of the readback;
- the exact values held in each diagnostic register after a mixed run of reads.

// File: rtl/edc_diag_pkg.sv
package edc_diag_pkg;

  typedef enum logic [2:0] {
    MD_ERRDATA = 3'b000,
    MD_DIAG    = 3'b001,
    MD_GENDET  = 3'b010,
    MD_NORMAL  = 3'b011,
    MD_INJECT  = 3'b100
  } edc_mode_e;

  localparam int CFG_W     = 7;
  localparam int BIT_CLR   = 3;
  localparam int BIT_PAR   = 4;
  localparam int BIT_RDM   = 5;
  localparam int BIT_DUAL  = 6;
  localparam int DSEL_W    = 3;
  localparam int ETYPE_W   = 2;

  localparam logic [ETYPE_W-1:0] ET_NONE   = 2'b00;
  localparam logic [ETYPE_W-1:0] ET_SINGLE = 2'b01;
  localparam logic [ETYPE_W-1:0] ET_MULTI  = 2'b10;

  typedef struct packed {
    logic       dual_fifo;
    logic       rd_mode;
    logic       par_even;
    logic [2:0] mode;
  } mode_cfg_t;

endpackage

// File: rtl/edc_mode_reg.sv
module edc_mode_reg
  import edc_diag_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_en,
  input  logic [CFG_W-1:0] wr_bits,
  output mode_cfg_t        cfg_o,
  output logic             clr_o
);

  mode_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (mode_en) begin
      cfg_d.mode      = wr_bits[2:0];
      cfg_d.par_even  = wr_bits[BIT_PAR];
      cfg_d.rd_mode   = wr_bits[BIT_RDM];
      cfg_d.dual_fifo = wr_bits[BIT_DUAL];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign cfg_o = cfg_q;
  assign clr_o = mode_en & wr_bits[BIT_CLR];

  // R1: register holds when not enabled
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_en |=> $stable(cfg_q));
  // R1: mode field follows the bus on an enabled write
  a_r1_load: assert property (@(posedge clk) disable iff (!rst_n)
    mode_en |=> cfg_q.mode == $past(wr_bits[2:0]));

endmodule

// File: rtl/edc_err_capture.sv
module edc_err_capture
  import edc_diag_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CHK_W  = 8,
  parameter int CNT_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               inj_mode,
  input  logic               chk_load,
  input  logic [CHK_W-1:0]   ld_chk,
  input  logic               rd_valid,
  input  logic [DATA_W-1:0]  rd_data,
  input  logic [CHK_W-1:0]   rd_chk,
  input  logic [CHK_W-1:0]   gen_chk,
  output logic               err_n,
  output logic               merr_n,
  output logic [CHK_W-1:0]   inj_q,
  output logic [CHK_W-1:0]   dchk_q,
  output logic [CHK_W-1:0]   syn_q,
  output logic [CNT_W-1:0]   cnt_q,
  output logic [ETYPE_W-1:0] type_q,
  output logic [DATA_W-1:0]  edata_q
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CHK_W-1:0]   eff_chk, syn;
  logic               is_err, is_multi;
  logic               seen_q, seen_d, err_n_d, merr_n_d;
  logic [CHK_W-1:0]   inj_d, dchk_d, syn_d;
  logic [CNT_W-1:0]   cnt_d;
  logic [ETYPE_W-1:0] type_d;
  logic [DATA_W-1:0]  edata_d;

  assign eff_chk  = inj_mode ? inj_q : rd_chk;
  assign syn      = eff_chk ^ gen_chk;
  assign is_err   = rd_valid && (syn != '0);
  assign is_multi = is_err && (inj_mode || !(^syn));

  always_comb begin
    inj_d    = inj_q;
    dchk_d   = dchk_q;
    syn_d    = syn_q;
    cnt_d    = cnt_q;
    type_d   = type_q;
    edata_d  = edata_q;
    seen_d   = seen_q;
    err_n_d  = err_n;
    merr_n_d = merr_n;
    if (clr) begin
      inj_d    = '0;
      dchk_d   = '0;
      syn_d    = '0;
      cnt_d    = '0;
      type_d   = ET_NONE;
      edata_d  = '0;
      seen_d   = 1'b0;
      err_n_d  = 1'b1;
      merr_n_d = 1'b1;
    end else begin
      if (chk_load && inj_mode) inj_d = ld_chk;
      if (rd_valid) begin
        err_n_d  = !is_err;
        merr_n_d = !is_multi;
      end
      if (is_err) begin
        syn_d  = syn;
        dchk_d = eff_chk;
        type_d = is_multi ? ET_MULTI : ET_SINGLE;
        if (cnt_q != CNT_MAX) cnt_d = cnt_q + CNT_ONE;
        if (!seen_q) begin
          edata_d = rd_data;
          seen_d  = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inj_q   <= '0;
      dchk_q  <= '0;
      syn_q   <= '0;
      cnt_q   <= '0;
      type_q  <= ET_NONE;
      edata_q <= '0;
      seen_q  <= 1'b0;
      err_n   <= 1'b1;
      merr_n  <= 1'b1;
    end else begin
      inj_q   <= inj_d;
      dchk_q  <= dchk_d;
      syn_q   <= syn_d;
      cnt_q   <= cnt_d;
      type_q  <= type_d;
      edata_q <= edata_d;
      seen_q  <= seen_d;
      err_n   <= err_n_d;
      merr_n  <= merr_n_d;
    end
  end

  // R4: multi-bit flag implies error flag
  a_r4_merr_with_err: assert property (@(posedge clk) disable iff (!rst_n)
    !merr_n |-> !err_n);
  // R4: flags move only on a read strobe or a clear
  a_r4_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_valid && !clr) |=> ($stable(err_n) && $stable(merr_n)));
  // R3: clear empties the diagnostic state
  a_r3_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0 && edata_q == '0 && syn_q == '0 && inj_q == '0
             && type_q == ET_NONE && err_n && merr_n));
  // R6: captured word is frozen after the first error
  a_r6_first_only: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !clr) |=> $stable(edata_q));
  // R8: count never wraps
  a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !clr) |=> cnt_q == CNT_MAX);
  // R5: latch only moves in injection mode
  a_r5_latch_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (!inj_mode && !clr) |=> $stable(inj_q));
  // R7: no read strobe leaves the syndrome record alone
  a_r7_syn_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_valid && !clr) |=> $stable(syn_q));

endmodule

// File: rtl/edc_readback.sv
module edc_readback
  import edc_diag_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CHK_W  = 8,
  parameter int CNT_W  = 8,
  parameter int SD_W   = 16
) (
  input  mode_cfg_t          cfg,
  input  logic [DSEL_W-1:0]  sel,
  input  logic [DATA_W-1:0]  edata,
  input  logic [CHK_W-1:0]   inj,
  input  logic [CHK_W-1:0]   dchk,
  input  logic [CHK_W-1:0]   syn,
  input  logic [CNT_W-1:0]   cnt,
  input  logic [ETYPE_W-1:0] etype,
  output logic [SD_W-1:0]    sd_out
);

  localparam int NSLICE = DATA_W / SD_W;
  localparam int SLW    = (NSLICE > 1) ? $clog2(NSLICE) : 1;

  logic [SD_W-1:0] slices [NSLICE];
  logic [SD_W-1:0] img, diag_word;

  for (genvar g = 0; g < NSLICE; g++) begin : g_slice
    assign slices[g] = edata[g*SD_W +: SD_W];
  end

  always_comb begin
    img = '0;
    img[2:0]      = cfg.mode;
    img[BIT_PAR]  = cfg.par_even;
    img[BIT_RDM]  = cfg.rd_mode;
    img[BIT_DUAL] = cfg.dual_fifo;
  end

  always_comb begin
    diag_word = '0;
    case (sel)
      3'd0:    diag_word[CHK_W-1:0]   = inj;
      3'd1:    diag_word[CHK_W-1:0]   = dchk;
      3'd2:    diag_word[CHK_W-1:0]   = syn;
      3'd3:    diag_word[CNT_W-1:0]   = cnt;
      3'd4:    diag_word[ETYPE_W-1:0] = etype;
      default: diag_word = '0;
    endcase
  end

  always_comb begin
    sd_out = '0;
    if (cfg.rd_mode)                sd_out = img;
    else if (cfg.mode == MD_ERRDATA) sd_out = slices[sel[SLW-1:0]];
    else if (cfg.mode == MD_DIAG)    sd_out = diag_word;
  end

endmodule

// File: rtl/edc_diag_ctrl.sv
module edc_diag_ctrl
  import edc_diag_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CHK_W  = 8,
  parameter int CNT_W  = 8,
  parameter int SD_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_en,
  input  logic [SD_W-1:0]   sd_in,
  input  logic              chk_load,
  input  logic [DSEL_W-1:0] diag_sel,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [CHK_W-1:0]  rd_chk,
  input  logic [CHK_W-1:0]  gen_chk,
  output logic [SD_W-1:0]   sd_out,
  output logic              err_n,
  output logic              merr_n,
  output logic              core_gen_en,
  output logic              core_correct_en,
  output logic              parity_even,
  output logic              fifo_dual
);

  logic [1:0]         rst_sync;
  logic               rst_int_n;
  mode_cfg_t          cfg;
  logic               clr;
  logic [CHK_W-1:0]   inj_q, dchk_q, syn_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [ETYPE_W-1:0] type_q;
  logic [DATA_W-1:0]  edata_q;
  logic               unused_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];
  assign unused_hi = ^sd_in[SD_W-1:CFG_W];

  edc_mode_reg u_mode (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .mode_en (mode_en),
    .wr_bits (sd_in[CFG_W-1:0]),
    .cfg_o   (cfg),
    .clr_o   (clr)
  );

  edc_err_capture #(.DATA_W(DATA_W), .CHK_W(CHK_W), .CNT_W(CNT_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .clr      (clr),
    .inj_mode (cfg.mode == MD_INJECT),
    .chk_load (chk_load),
    .ld_chk   (sd_in[CHK_W-1:0]),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .rd_chk   (rd_chk),
    .gen_chk  (gen_chk),
    .err_n    (err_n),
    .merr_n   (merr_n),
    .inj_q    (inj_q),
    .dchk_q   (dchk_q),
    .syn_q    (syn_q),
    .cnt_q    (cnt_q),
    .type_q   (type_q),
    .edata_q  (edata_q)
  );

  edc_readback #(.DATA_W(DATA_W), .CHK_W(CHK_W), .CNT_W(CNT_W), .SD_W(SD_W)) u_rb (
    .cfg    (cfg),
    .sel    (diag_sel),
    .edata  (edata_q),
    .inj    (inj_q),
    .dchk   (dchk_q),
    .syn    (syn_q),
    .cnt    (cnt_q),
    .etype  (type_q),
    .sd_out (sd_out)
  );

  assign core_gen_en     = (cfg.mode == MD_GENDET) || (cfg.mode == MD_NORMAL)
                        || (cfg.mode == MD_INJECT);
  assign core_correct_en = (cfg.mode == MD_NORMAL);
  assign parity_even     = cfg.par_even;
  assign fifo_dual       = cfg.dual_fifo;

  // R2: correction never runs without generation
  a_r2_correct_needs_gen: assert property (@(posedge clk) disable iff (!rst_int_n)
    core_correct_en |-> core_gen_en);
  // R11: readback in non-readout modes stays quiet unless register image selected
  a_r11_quiet_bus: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!cfg.rd_mode && core_gen_en) |-> sd_out == '0);

endmodule

// File: tb/test_edc_diag_ctrl.sv
`timescale 1ns/1ps
module test_edc_diag_ctrl;

  typedef struct {
    int          which;
    logic [15:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_en, chk_load, rd_valid;
  logic [15:0] sd_in;
  logic [2:0]  diag_sel;
  logic [63:0] rd_data;
  logic [7:0]  rd_chk, gen_chk;
  logic [15:0] sd_out;
  logic        err_n, merr_n, core_gen_en, core_correct_en, parity_even, fifo_dual;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  edc_diag_ctrl i_edc_diag_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .sd_in(sd_in),
    .chk_load(chk_load), .diag_sel(diag_sel), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_chk(rd_chk), .gen_chk(gen_chk),
    .sd_out(sd_out), .err_n(err_n), .merr_n(merr_n),
    .core_gen_en(core_gen_en), .core_correct_en(core_correct_en),
    .parity_even(parity_even), .fifo_dual(fifo_dual)
  );

  // 0 sd_out, 1 err_n, 2 merr_n, 3 core_gen_en, 4 core_correct_en, 5 parity_even, 6 fifo_dual
  function automatic logic [15:0] observe(int which);
    case (which)
      0: return sd_out;
      1: return {15'd0, err_n};
      2: return {15'd0, merr_n};
      3: return {15'd0, core_gen_en};
      4: return {15'd0, core_correct_en};
      5: return {15'd0, parity_even};
      default: return {15'd0, fifo_dual};
    endcase
  endfunction

  // monitor: compares every queued item after the next rising edge
  always @(posedge clk) begin
    #3;
    while (q.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it  = q.pop_front();
      act = observe(it.which);
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s sig%0d actual=%h expected=%h", it.tag, it.which, act, it.exp);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected<20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic expect_sig(input int which, input logic [15:0] exp, input string tag);
    item_t it;
    it.which = which; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic step();
    @(negedge clk);
    mode_en = 1'b0; chk_load = 1'b0; rd_valid = 1'b0;
  endtask

  task automatic mode_wr(input logic [15:0] v);
    step(); sd_in = v; mode_en = 1'b1;
  endtask

  task automatic mem_rd(input logic [63:0] d, input logic [7:0] c, input logic [7:0] g);
    step(); rd_data = d; rd_chk = c; gen_chk = g; rd_valid = 1'b1;
  endtask

  task automatic sel_rd(input logic [2:0] s, input logic [15:0] exp, input string tag);
    step(); diag_sel = s; expect_sig(0, exp, tag);
  endtask

  initial begin
    rst_n = 1'b0; mode_en = 1'b0; chk_load = 1'b0; rd_valid = 1'b0;
    sd_in = '0; diag_sel = '0; rd_data = '0; rd_chk = '0; gen_chk = '0;
    @(negedge clk);
    expect_sig(0, 16'h0, "R13 sd_out in reset");
    expect_sig(1, 16'h1, "R13 err_n in reset");
    expect_sig(2, 16'h1, "R13 merr_n in reset");
    expect_sig(3, 16'h0, "R13 gen_en in reset");
    @(negedge clk); rst_n = 1'b1;
    step(); step(); step();

    mode_wr(16'h0003);
    expect_sig(3, 16'h1, "R2 normal gen");
    expect_sig(4, 16'h1, "R2 normal correct");
    step(); sd_in = 16'h0002;
    expect_sig(4, 16'h1, "R1 write ignored without enable");

    mem_rd(64'h0123_4567_89AB_CDEF, 8'h0C, 8'h0D);
    expect_sig(1, 16'h0, "R4 single err_n");
    expect_sig(2, 16'h1, "R4 single merr_n");
    mem_rd(64'hFFFF_FFFF_FFFF_FFFF, 8'h0C, 8'h0F);
    expect_sig(1, 16'h0, "R4 multi err_n");
    expect_sig(2, 16'h0, "R4 multi merr_n");
    mem_rd(64'h5555_5555_5555_5555, 8'h33, 8'h33);
    expect_sig(1, 16'h1, "R4 clean err_n");
    expect_sig(2, 16'h1, "R4 clean merr_n");
    step(); sd_in = 16'h00FF; chk_load = 1'b1;

    mode_wr(16'h0001);
    expect_sig(3, 16'h0, "R2 diag gen");
    expect_sig(4, 16'h0, "R2 diag correct");
    sel_rd(3'd0, 16'h0000, "R5 latch untouched outside injection");
    sel_rd(3'd1, 16'h000C, "R7 compared checkbits");
    sel_rd(3'd2, 16'h0003, "R7 last syndrome");
    sel_rd(3'd3, 16'h0002, "R8 count");
    sel_rd(3'd4, 16'h0002, "R7 type multi");
    sel_rd(3'd5, 16'h0000, "R10 spare index");
    sel_rd(3'd7, 16'h0000, "R10 spare index 7");

    mode_wr(16'h0000);
    sel_rd(3'd0, 16'hCDEF, "R9 slice0");
    sel_rd(3'd1, 16'h89AB, "R9 slice1");
    sel_rd(3'd2, 16'h4567, "R6 slice2 first error kept");
    sel_rd(3'd3, 16'h0123, "R9 slice3");

    mode_wr(16'h0020);
    expect_sig(0, 16'h0020, "R11 image mode0");
    mode_wr(16'h0052);
    expect_sig(3, 16'h1, "R2 gendet gen");
    expect_sig(4, 16'h0, "R2 gendet correct");
    expect_sig(5, 16'h1, "R12 parity even");
    expect_sig(6, 16'h1, "R12 dual buffer");
    expect_sig(0, 16'h0000, "R11 quiet in gendet");
    mode_wr(16'hFFA2);
    expect_sig(0, 16'h0022, "R1 upper bits ignored");
    expect_sig(5, 16'h0, "R12 parity odd");
    expect_sig(6, 16'h0, "R12 single buffer");
    mem_rd(64'h1, 8'h00, 8'h80);
    expect_sig(1, 16'h0, "R4 gendet detect");
    expect_sig(2, 16'h1, "R4 gendet single");

    mode_wr(16'h0004);
    expect_sig(3, 16'h1, "R2 inject gen");
    expect_sig(4, 16'h0, "R2 inject correct");
    step(); sd_in = 16'h00A5; chk_load = 1'b1;
    mem_rd(64'h2, 8'h00, 8'hA5);
    expect_sig(1, 16'h1, "R5 latch replaces stored");
    mem_rd(64'h3, 8'hA4, 8'hA4);
    expect_sig(1, 16'h0, "R5 inject mismatch err_n");
    expect_sig(2, 16'h0, "R5 inject mismatch merr_n");

    mode_wr(16'h0001);
    sel_rd(3'd0, 16'h00A5, "R5 latch value");
    sel_rd(3'd1, 16'h00A5, "R7 compared latch");
    sel_rd(3'd2, 16'h0001, "R7 inject syndrome");
    sel_rd(3'd3, 16'h0004, "R8 count 4");
    sel_rd(3'd4, 16'h0002, "R7 inject type");

    mode_wr(16'h0003);
    for (int i = 0; i < 300; i++) mem_rd(64'(i), 8'h01, 8'h00);
    mode_wr(16'h0001);
    sel_rd(3'd3, 16'h00FF, "R8 saturated");
    sel_rd(3'd4, 16'h0001, "R7 single type");

    mode_wr(16'h0029);
    expect_sig(1, 16'h1, "R3 flag released");
    expect_sig(0, 16'h0021, "R3 clear not stored");
    mode_wr(16'h0001);
    sel_rd(3'd0, 16'h0000, "R3 latch cleared");
    sel_rd(3'd1, 16'h0000, "R3 checkbits cleared");
    sel_rd(3'd2, 16'h0000, "R3 syndrome cleared");
    sel_rd(3'd3, 16'h0000, "R3 count cleared");
    sel_rd(3'd4, 16'h0000, "R3 type cleared");
    mode_wr(16'h0000);
    sel_rd(3'd0, 16'h0000, "R3 error data cleared");

    mem_rd(64'hAAAA_BBBB_CCCC_DDDD, 8'h10, 8'h00);
    mem_rd(64'h1111_2222_3333_4444, 8'h10, 8'h00);
    sel_rd(3'd3, 16'hAAAA, "R6 first error after clear");
    sel_rd(3'd0, 16'hDDDD, "R6 low slice after clear");

    step(); step(); step();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule